// File: doc/BRIEF.md
# Converter Command/Data Serial Port

This block is a slave serial port for the register bank of a data converter. A host talks to it over four wires: an active-low select, a bit clock, a data input and a data output. Each access is a 32-clock frame. The first 8 clocks carry a command byte. The next 24 clocks carry a data word, shifted most significant bit first. The command byte decides whether that word is stored into one of sixteen 24-bit registers or returned from one. All four pins are brought into a faster system clock domain through synchronizers. Bit-clock edges are found there by edge detection.

The converter side raises a one-cycle done strobe together with a 24-bit result. The port keeps the result and shows readiness by pulling the data output low between frames. The next 8-clock word the host sends only clears that flag, whatever its bits are. The 24 clocks that follow stream the stored result out. With select held low all the time, the port works as a three-wire link that keeps frame alignment by counting clocks alone.

Top module: `adcsp_port`

## Requirements
- R1: The output enable `sdoOe` is 0 in every cycle in which `csN` is 1.
- R2: Bit-clock edges that occur while `csN` is 1 are ignored: the next frame with `csN` low is decoded from its own first edge.
- R3: A frame is 8 command clocks and then 24 data clocks, sampled on rising bit-clock edges, most significant bit first. Command bit 7 = 0 is a write. Command bits 3:0 pick the register. The write takes effect only after the 32nd rising edge.
- R4: Command bit 7 = 1 is a read. The addressed register appears on `sdoOut` most significant bit first. Each bit changes on a falling bit-clock edge, so the host samples it on the following rising edge.
- R5: Command bits 6:4 have no effect on which register is accessed or on the direction.
- R6: A rise of `csN` part-way through a frame abandons it. No register changes, and the next frame starts again at its first command bit.
- R7: With `csN` held low, frames follow each other back to back, aligned by counting 32 clocks each.
- R8: A `convDone` pulse stores `convData` and sets a ready flag. Outside the data phase, `sdoOut` is 0 while the flag is set and 1 while it is clear.
- R9: If the flag is set at the first rising edge of a frame, the 8-bit word is a clear word whatever its bits are. The flag clears after its 8th edge, the stored result is shifted out most significant bit first over the next 24 clocks, and no register is written.
- R10: After reset every register reads 0 and the ready flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bit clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low select; may be tied low |
| sclk | input | 1 | Serial bit clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdoOut | output | 1 | Serial data to the host |
| sdoOe | output | 1 | Drive enable for the data output pad |
| convDone | input | 1 | One-cycle strobe: a new conversion result is ready |
| convData | input | 24 | Conversion result, valid with `convDone` |

## Verification
If the bit counter goes wrong, every later frame is shifted, so the next read returns a rotated or mixed word within one frame. That is why the abort and select-ignored cases are each followed at once by a read of a known register. If the write-commit logic goes wrong, it shows at the next readback of the target register. If the flag or the direction state goes wrong, `sdoOut` shows it within a few system clocks of the select falling: either the level between frames is wrong, or the clear word returns register contents instead of the result.

// File: rtl/adcsp_pkg.sv
package adcsp_pkg;
  typedef enum logic [1:0] {
    PH_CMD = 2'd0,
    PH_WR  = 2'd1,
    PH_RD  = 2'd2,
    PH_RES = 2'd3
  } phase_e;

  typedef struct packed {
    logic shiftIn;
    logic latchCmd;
    logic loadReg;
    logic loadRes;
    logic shiftOut;
    logic commit;
    logic clrFlag;
    logic cmdPhase;
  } strobe_t;
endpackage

// File: rtl/adcsp_sync.sv
module adcsp_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= din;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/adcsp_ctrl.sv
module adcsp_ctrl
  import adcsp_pkg::*;
#(
  parameter int CMD_W = 8,
  parameter int DATA_W = 24,
  localparam int FRAME = CMD_W + DATA_W,
  localparam int CNT_W = $clog2(FRAME)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csHigh,
  input  logic             riseEv,
  input  logic             fallEv,
  input  logic             flagPend,
  input  logic             cmdRead,
  output strobe_t          stb,
  output phase_e           phase,
  output logic [CNT_W-1:0] bitCnt
);
  localparam logic [CNT_W-1:0] CMD_LAST   = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME - 1);

  logic clrWord;
  logic clrWordNow;
  logic act;

  // a clear word is decided by the flag seen at the first edge of the frame
  assign clrWordNow = (bitCnt == '0) ? flagPend : clrWord;
  assign act = !csHigh && riseEv;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_CMD;
      bitCnt  <= '0;
      clrWord <= 1'b0;
    end else if (csHigh) begin
      phase   <= PH_CMD;
      bitCnt  <= '0;
      clrWord <= 1'b0;
    end else if (riseEv) begin
      bitCnt <= (bitCnt == FRAME_LAST) ? '0 : bitCnt + 1'b1;
      if (bitCnt == '0) clrWord <= flagPend;
      if (bitCnt == CMD_LAST) begin
        if (clrWordNow)   phase <= PH_RES;
        else if (cmdRead) phase <= PH_RD;
        else              phase <= PH_WR;
      end
      if (bitCnt == FRAME_LAST) phase <= PH_CMD;
    end
  end

  always_comb begin
    stb          = '0;
    stb.shiftIn  = act;
    stb.latchCmd = act && (bitCnt == CMD_LAST);
    stb.loadReg  = stb.latchCmd && !clrWordNow && cmdRead;
    stb.loadRes  = stb.latchCmd && clrWordNow;
    stb.clrFlag  = stb.loadRes;
    stb.commit   = act && (bitCnt == FRAME_LAST) && (phase == PH_WR);
    stb.shiftOut = !csHigh && fallEv && ((phase == PH_RD) || (phase == PH_RES));
    stb.cmdPhase = (phase == PH_CMD);
  end
endmodule

// File: rtl/adcsp_dp.sv
module adcsp_dp
  import adcsp_pkg::*;
#(
  parameter int CMD_W = 8,
  parameter int DATA_W = 24,
  parameter int NUM_REGS = 16,
  localparam int ADDR_W = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic              sdiS,
  input  logic              convDone,
  input  logic [DATA_W-1:0] convData,
  output logic              cmdRead,
  output logic              flagPend,
  output logic              sdoReg
);
  logic [DATA_W-1:0] inShift;
  logic [DATA_W-1:0] wordIn;
  logic [DATA_W-1:0] outShift;
  logic [DATA_W-1:0] resultQ;
  logic [ADDR_W-1:0] addrQ;
  logic [ADDR_W-1:0] cmdAddr;
  logic [DATA_W-1:0] regQ [NUM_REGS];

  assign wordIn  = {inShift[DATA_W-2:0], sdiS};
  assign cmdRead = inShift[CMD_W-2];
  assign cmdAddr = wordIn[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inShift <= '0;
      addrQ   <= '0;
    end else begin
      if (stb.shiftIn)  inShift <= wordIn;
      if (stb.latchCmd) addrQ   <= cmdAddr;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) q <= '0;
      else if (stb.commit && (addrQ == ADDR_W'(g))) q <= wordIn;
    end
    assign regQ[g] = q;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultQ  <= '0;
      flagPend <= 1'b0;
    end else if (convDone) begin
      resultQ  <= convData;
      flagPend <= 1'b1;
    end else if (stb.clrFlag) begin
      flagPend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outShift <= '0;
      sdoReg   <= 1'b1;
    end else begin
      if (stb.loadReg)       outShift <= regQ[cmdAddr];
      else if (stb.loadRes)  outShift <= resultQ;
      else if (stb.shiftOut) outShift <= {outShift[DATA_W-2:0], 1'b0};
      if (stb.cmdPhase)      sdoReg <= !flagPend;
      else if (stb.shiftOut) sdoReg <= outShift[DATA_W-1];
    end
  end
endmodule

// File: rtl/adcsp_port.sv
module adcsp_port
  import adcsp_pkg::*;
#(
  parameter int CMD_W = 8,
  parameter int DATA_W = 24,
  parameter int NUM_REGS = 16,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W = $clog2(CMD_W + DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdoOut,
  output logic              sdoOe,
  input  logic              convDone,
  input  logic [DATA_W-1:0] convData
);
  logic [2:0] pinS;
  logic csHigh, sclkS, sdiS, sclkQ;
  logic riseEv, fallEv;
  logic flagPend, cmdRead, sdoReg;
  strobe_t stb;
  phase_e phase;
  logic [CNT_W-1:0] bitCnt;

  adcsp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) uSync (
    .clk(clk), .rstN(rstN), .din({csN, sclk, sdi}), .dout(pinS)
  );
  assign csHigh = pinS[2];
  assign sclkS  = pinS[1];
  assign sdiS   = pinS[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sclkQ <= 1'b0;
    else       sclkQ <= sclkS;
  end
  assign riseEv = sclkS && !sclkQ;
  assign fallEv = !sclkS && sclkQ;

  adcsp_ctrl #(.CMD_W(CMD_W), .DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .csHigh(csHigh), .riseEv(riseEv), .fallEv(fallEv),
    .flagPend(flagPend), .cmdRead(cmdRead), .stb(stb), .phase(phase), .bitCnt(bitCnt)
  );

  adcsp_dp #(.CMD_W(CMD_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .sdiS(sdiS), .convDone(convDone),
    .convData(convData), .cmdRead(cmdRead), .flagPend(flagPend), .sdoReg(sdoReg)
  );

  // pad released at once on select high, enabled only after it is seen low
  assign sdoOe  = !csN && !csHigh;
  assign sdoOut = sdoReg;
endmodule

// File: rtl/adcsp_chk.sv
module adcsp_chk
  import adcsp_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             csN,
  input logic             sdoOe,
  input logic             sdoOut,
  input logic             convDone,
  input logic             flagPend,
  input logic             csHigh,
  input logic             riseEv,
  input logic             fallEv,
  input strobe_t          stb,
  input phase_e           phase,
  input logic [CNT_W-1:0] bitCnt
);
  // R1
  oe_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sdoOe);

  // R6
  abort_nowrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    csHigh |-> (!stb.commit && !stb.shiftIn));

  // R3
  commit_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit |-> (riseEv && (bitCnt == {CNT_W{1'b1}})));

  // R4
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!csHigh && (phase == PH_RD || phase == PH_RES) && !fallEv && !riseEv)
      |=> $stable(sdoOut));

  // R8
  flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    convDone |=> flagPend);

  // R9
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.clrFlag && !convDone) |=> !flagPend);
endmodule

bind adcsp_port adcsp_chk #(.CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .csN(csN), .sdoOe(sdoOe), .sdoOut(sdoOut),
  .convDone(convDone), .flagPend(flagPend), .csHigh(csHigh), .riseEv(riseEv),
  .fallEv(fallEv), .stb(stb), .phase(phase), .bitCnt(bitCnt)
);

// File: tb/tb_adcsp_port.sv
module tb_adcsp_port;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;
  localparam int NVEC = 9;

  logic clk = 1'b0;
  logic rstN, csN, sclk, sdi, convDone;
  logic [23:0] convData;
  logic sdoOut, sdoOe;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adcsp_port dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .sdoOut(sdoOut), .sdoOe(sdoOe), .convDone(convDone), .convData(convData)
  );

  // {check, cmd[7:0], writeData[23:0], expected[23:0]}
  localparam logic [56:0] VEC [NVEC] = '{
    {1'b0, 8'h01, 24'hA5C3F0, 24'h000000},  // R3 write reg1
    {1'b0, 8'h0F, 24'h800001, 24'h000000},  // R3 write reg15
    {1'b0, 8'h00, 24'hFFFFFF, 24'h000000},  // R3 write reg0
    {1'b1, 8'h81, 24'h000000, 24'hA5C3F0},  // R4 read reg1
    {1'b1, 8'h8F, 24'h000000, 24'h800001},  // R4 read reg15
    {1'b1, 8'hF0, 24'h000000, 24'hFFFFFF},  // R5 read reg0, bits 6:4 set
    {1'b0, 8'h71, 24'h123456, 24'h000000},  // R5 write reg1, bits 6:4 set
    {1'b1, 8'h81, 24'h000000, 24'h123456},  // R5 read back
    {1'b1, 8'h87, 24'h000000, 24'h000000}   // R10 untouched reg7 is zero
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] cmd, input logic [23:0] wd, input bit useCs,
                      input int nBits, output logic [23:0] rd);
    logic [31:0] frame;
    frame = {cmd, wd};
    rd = '0;
    if (useCs) begin csN = 1'b0; tick(4); end
    for (int i = 0; i < nBits; i++) begin
      sdi = frame[31-i];
      tick(HALF);
      if (i >= 8) rd = {rd[22:0], sdoOut};
      sclk = 1'b1;
      tick(HALF);
      sclk = 1'b0;
    end
    sdi = 1'b0;
    tick(HALF);
    if (useCs) begin csN = 1'b1; tick(4); end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    finish_run();
  end

  initial begin
    logic [23:0] rd;
    csN = 1'b1; sclk = 1'b0; sdi = 1'b0; convDone = 1'b0; convData = '0; rstN = 1'b0;
    tick(5);
    rstN = 1'b1;
    tick(4);
    check("R1 oe with cs high", 24'(sdoOe), 24'h0);
    csN = 1'b0; tick(4);
    check("R10 idle sdo after reset", 24'(sdoOut), 24'h1);
    check("R1 oe with cs low", 24'(sdoOe), 24'h1);
    csN = 1'b1; tick(4);

    for (int v = 0; v < NVEC; v++) begin
      xfer(VEC[v][55:48], VEC[v][47:24], 1'b1, 32, rd);
      if (VEC[v][56]) check($sformatf("R4 vector %0d", v), rd, VEC[v][23:0]);
    end

    // R2: clock edges with select high are ignored
    sdi = 1'b1;
    for (int k = 0; k < 10; k++) begin sclk = ~sclk; tick(HALF); end
    sclk = 1'b0; sdi = 1'b0; tick(4);
    xfer(8'h81, 24'h0, 1'b1, 32, rd);
    check("R2 read after ignored edges", rd, 24'h123456);

    // R6: abort in data and in command phase
    xfer(8'h02, 24'h111111, 1'b1, 32, rd);
    xfer(8'h02, 24'h222222, 1'b1, 20, rd);
    xfer(8'h82, 24'h0, 1'b1, 32, rd);
    check("R6 data-phase abort", rd, 24'h111111);
    xfer(8'h02, 24'h333333, 1'b1, 5, rd);
    xfer(8'h82, 24'h0, 1'b1, 32, rd);
    check("R6 command-phase abort", rd, 24'h111111);

    // R7: three-wire, select stays low
    csN = 1'b0; tick(4);
    xfer(8'h03, 24'h5A5A5A, 1'b0, 32, rd);
    xfer(8'h83, 24'h0, 1'b0, 32, rd);
    check("R7 back-to-back reg3", rd, 24'h5A5A5A);
    xfer(8'h8F, 24'h0, 1'b0, 32, rd);
    check("R7 back-to-back reg15", rd, 24'h800001);
    csN = 1'b1; tick(4);

    // R8/R9: conversion flag, clear word, result stream
    convData = 24'hC0FFEE; convDone = 1'b1; tick(1);
    convDone = 1'b0; convData = 24'h0;
    csN = 1'b0; tick(4);
    check("R8 flag shown low", 24'(sdoOut), 24'h0);
    xfer(8'h05, 24'hFFFFFF, 1'b0, 32, rd);
    check("R9 result after clear word", rd, 24'hC0FFEE);
    tick(4);
    check("R8 flag cleared", 24'(sdoOut), 24'h1);
    csN = 1'b1; tick(4);
    check("R1 oe after release", 24'(sdoOe), 24'h0);
    xfer(8'h85, 24'h0, 1'b1, 32, rd);
    check("R9 clear word wrote nothing", rd, 24'h000000);

    // R9 with select toggled per frame and a read-looking clear word
    convData = 24'h0F1E2D; convDone = 1'b1; tick(1);
    convDone = 1'b0;
    xfer(8'h81, 24'h0, 1'b1, 32, rd);
    check("R9 clear word with read bits", rd, 24'h0F1E2D);
    xfer(8'h81, 24'h0, 1'b1, 32, rd);
    check("R3 register intact after result", rd, 24'h123456);

    finish_run();
  end
endmodule